// File: doc/BRIEF.md
# Byte-Lane Packing Data Queues

This block sits between a 32-bit host register port and a byte-serial two-wire bus engine. On the transmit path the host writes whole words into a word queue. An unpacker then presents the bytes of those words to the engine one at a time, starting from the least significant lane. On the receive path a packer collects bytes from the engine into words, lowest lane first, and places them in a second word queue for the host to read.

Each direction is armed by a command that carries a byte count. That count decides how many lanes of the final word are used, so a transfer may end in the middle of a word on either side. For a bus write, the host places the address byte, meaning the 7-bit address shifted left once with the direction bit in bit 0, in lane 0 of the first word. Payload bytes follow in lanes 1 to 3 and then in later words.

A flush input empties both queues and returns both lane counters to their start state. Host writes into a full transmit queue and host reads from an empty receive queue have no effect, but each one raises a sticky error flag.

Top module: `lane_pack_queues`

## Requirements
- R1: Transmit bytes leave each word in lane order: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R2: After lane 3 of a word, the next byte comes from lane 0 of the next queued word, so an address byte in lane 0 of the first word is the first byte on the bus.
- R3: A transmit command of N bytes presents exactly N bytes. Unused upper lanes of the last word are discarded, and the next command starts on a fresh word.
- R4: `eng_tx_last` is high together with the final byte of a transmit command and low for every other byte.
- R5: The first received byte of a command lands in bits 7:0 of a word, and each later byte goes into the next higher lane.
- R6: A received word is queued after four bytes or when the command's byte count runs out, whichever comes first. Lanes that were not filled read as zero.
- R7: `rx_empty` is high exactly when no received word is waiting. Read data appears on `rx_rd_data` one clock after `rx_rd_en`.
- R8: `soft_rst` empties both queues, ends any active command on both sides, clears both lane positions and clears both error flags.
- R9: A host write while `tx_full` is high is dropped, and it sets `tx_overflow`, which stays set until a reset or a flush.
- R10: A host read while `rx_empty` is high changes nothing, and it sets `rx_underflow`, which stays set until a reset or a flush.
- R11: While `eng_tx_valid` is high and `eng_tx_ready` is low, `eng_tx_byte` holds its value.
- R12: A command that arrives while the same direction is busy is ignored. Engine bytes that arrive with no receive command active are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Flush of both queues, lane state and error flags |
| tx_wr_en | input | 1 | Host writes a transmit word |
| tx_wr_data | input | WORD_W | Transmit word, lane 0 goes out first |
| tx_full | output | 1 | Transmit queue full |
| tx_overflow | output | 1 | Sticky: a write was made while the queue was full |
| tx_cmd_valid | input | 1 | Starts a transmit command |
| tx_cmd_len | input | LEN_W | Transmit byte count, address byte included |
| tx_busy | output | 1 | Transmit command still has bytes left |
| eng_tx_valid | output | 1 | A byte is offered to the engine |
| eng_tx_byte | output | 8 | Offered byte |
| eng_tx_last | output | 1 | Offered byte is the last byte of the command |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| rx_cmd_valid | input | 1 | Starts a receive command |
| rx_cmd_len | input | LEN_W | Receive byte count |
| rx_busy | output | 1 | Receive command still expects bytes |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| rx_rd_en | input | 1 | Host pops a received word |
| rx_rd_data | output | WORD_W | Popped word, valid one clock after the pop |
| rx_empty | output | 1 | Receive queue empty |
| rx_underflow | output | 1 | Sticky: a read was made while the queue was empty |

## Verification
Both paths are swept over every byte count from 1 to 9. This covers a single address byte, each partial final word, exactly full words and transfers that cross two word boundaries. Mismatched lanes, stray fill bytes and misplaced word edges all show up in these sweeps. On transmit, filler is placed in unused lanes so that an unpacker reading past the count is caught. Engine stalls on chosen bytes separate a held byte from one that moves on early. Further runs fill the transmit queue and write past it, read the receive queue while empty, issue a command while the same side is busy, and flush with partial words on both sides. A following command then shows that no stale word or lane position survived.

// File: rtl/lpq_pkg.sv
package lpq_pkg;
  localparam int BYTE_W = 8;

  function automatic int lanes_of(input int word_w);
    return word_w / BYTE_W;
  endfunction
endpackage

// File: rtl/lpq_fifo.sv
module lpq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  // Storage array without reset, so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  // R9: a write into a full queue leaves the occupancy unchanged
  a_r9_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en && !flush) |=> (count == $past(count)));

  // R10: a read from an empty queue leaves it empty
  a_r10_empty_read_inert: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en && !flush) |=> empty);
endmodule

// File: rtl/lpq_tx_unpack.sv
module lpq_tx_unpack
  import lpq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cmd_valid,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] q_data,
  output logic              q_pop,
  output logic              busy,
  output logic              eng_valid,
  output logic [BYTE_W-1:0] eng_byte,
  output logic              eng_last,
  input  logic              eng_ready
);
  localparam int LANES = lanes_of(WORD_W);
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LW-1:0] TOP_LANE = LW'(LANES - 1);

  logic [WORD_W-1:0] cur_word;
  logic [LW-1:0]     lane;
  logic [LEN_W-1:0]  left;
  logic              have_word, pend, fire;

  assign busy      = (left != '0);
  assign eng_valid = have_word;
  assign eng_last  = have_word && (left == LEN_W'(1));
  assign eng_byte  = cur_word[lane*BYTE_W +: BYTE_W];
  assign fire      = have_word && eng_ready;
  assign q_pop     = !have_word && !pend && busy && !q_empty;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cur_word  <= '0;
      lane      <= '0;
      left      <= '0;
      have_word <= 1'b0;
      pend      <= 1'b0;
    end else if (cmd_valid && !busy) begin
      left      <= cmd_len;
      lane      <= '0;
      have_word <= 1'b0;
      pend      <= 1'b0;
    end else begin
      if (q_pop) pend <= 1'b1;
      if (pend) begin
        cur_word  <= q_data;
        have_word <= 1'b1;
        pend      <= 1'b0;
      end
      if (fire) begin
        left <= left - 1'b1;
        if (lane == TOP_LANE || left == LEN_W'(1)) begin
          have_word <= 1'b0;
          lane      <= '0;
        end else begin
          lane <= lane + 1'b1;
        end
      end
    end
  end

  // R11: an offered byte is held until the engine takes it
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready && !flush) |=> (eng_valid && $stable(eng_byte)));

  // R3: no byte is offered once the command's count is used up
  a_r3_no_excess_byte: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && eng_ready && eng_last && !flush) |=> !eng_valid);
endmodule

// File: rtl/lpq_rx_pack.sv
module lpq_rx_pack
  import lpq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              cmd_valid,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              eng_valid,
  input  logic [BYTE_W-1:0] eng_byte,
  input  logic              q_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word,
  output logic              busy
);
  localparam int LANES = lanes_of(WORD_W);
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LW-1:0] TOP_LANE = LW'(LANES - 1);

  logic [WORD_W-1:0] acc, acc_next;
  logic [LW-1:0]     lane;
  logic [LEN_W-1:0]  left;
  logic              take, close;
  logic              push_r;

  assign busy  = (left != '0);
  assign take  = eng_valid && busy;
  assign close = take && (lane == TOP_LANE || left == LEN_W'(1));
  assign push  = push_r && !q_full;

  always_comb begin
    acc_next = acc;
    acc_next[lane*BYTE_W +: BYTE_W] = eng_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc       <= '0;
      lane      <= '0;
      left      <= '0;
      push_r    <= 1'b0;
      push_word <= '0;
    end else begin
      push_r <= close;
      if (close) push_word <= acc_next;
      if (cmd_valid && !busy) begin
        left <= cmd_len;
        lane <= '0;
        acc  <= '0;
      end else if (take) begin
        left <= left - 1'b1;
        if (close) begin
          acc  <= '0;
          lane <= '0;
        end else begin
          acc  <= acc_next;
          lane <= lane + 1'b1;
        end
      end
    end
  end

  // R8: a flush leaves no partial word and no active count behind
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!busy && lane == '0 && acc == '0));

  // R12: a byte with no active command produces no word
  a_r12_idle_byte_ignored: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !busy && !flush) |=> !push_r);
endmodule

// File: rtl/lane_pack_queues.sv
module lane_pack_queues
  import lpq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              tx_wr_en,
  input  logic [WORD_W-1:0] tx_wr_data,
  output logic              tx_full,
  output logic              tx_overflow,
  input  logic              tx_cmd_valid,
  input  logic [LEN_W-1:0]  tx_cmd_len,
  output logic              tx_busy,
  output logic              eng_tx_valid,
  output logic [7:0]        eng_tx_byte,
  output logic              eng_tx_last,
  input  logic              eng_tx_ready,
  input  logic              rx_cmd_valid,
  input  logic [LEN_W-1:0]  rx_cmd_len,
  output logic              rx_busy,
  input  logic              eng_rx_valid,
  input  logic [7:0]        eng_rx_byte,
  input  logic              rx_rd_en,
  output logic [WORD_W-1:0] rx_rd_data,
  output logic              rx_empty,
  output logic              rx_underflow
);
  logic              txq_empty, txq_pop;
  logic [WORD_W-1:0] txq_data;
  logic              rxq_full, rxq_push;
  logic [WORD_W-1:0] rxq_word;

  lpq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(txq_pop), .rd_data(txq_data),
    .full(tx_full), .empty(txq_empty)
  );

  lpq_tx_unpack #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .cmd_valid(tx_cmd_valid), .cmd_len(tx_cmd_len),
    .q_empty(txq_empty), .q_data(txq_data), .q_pop(txq_pop),
    .busy(tx_busy), .eng_valid(eng_tx_valid), .eng_byte(eng_tx_byte),
    .eng_last(eng_tx_last), .eng_ready(eng_tx_ready)
  );

  lpq_rx_pack #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .cmd_valid(rx_cmd_valid), .cmd_len(rx_cmd_len),
    .eng_valid(eng_rx_valid), .eng_byte(eng_rx_byte),
    .q_full(rxq_full), .push(rxq_push), .push_word(rxq_word),
    .busy(rx_busy)
  );

  lpq_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(soft_rst),
    .wr_en(rxq_push), .wr_data(rxq_word),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data),
    .full(rxq_full), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      tx_overflow  <= 1'b0;
      rx_underflow <= 1'b0;
    end else begin
      if (tx_wr_en && tx_full)  tx_overflow  <= 1'b1;
      if (rx_rd_en && rx_empty) rx_underflow <= 1'b1;
    end
  end

  // R9: the overflow flag is sticky until a flush
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (tx_overflow && !soft_rst) |=> tx_overflow);

  // R10: the underflow flag is sticky until a flush
  a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_underflow && !soft_rst) |=> rx_underflow);
endmodule

// File: tb/lane_pack_queues_bench.sv
module lane_pack_queues_bench;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 4;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst, soft_rst;
  logic              tx_wr_en;
  logic [WORD_W-1:0] tx_wr_data;
  logic              tx_full, tx_overflow;
  logic              tx_cmd_valid;
  logic [LEN_W-1:0]  tx_cmd_len;
  logic              tx_busy;
  logic              eng_tx_valid, eng_tx_last, eng_tx_ready;
  logic [7:0]        eng_tx_byte;
  logic              rx_cmd_valid;
  logic [LEN_W-1:0]  rx_cmd_len;
  logic              rx_busy;
  logic              eng_rx_valid;
  logic [7:0]        eng_rx_byte;
  logic              rx_rd_en;
  logic [WORD_W-1:0] rx_rd_data;
  logic              rx_empty, rx_underflow;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_b [0:63];

  always #10 clk = ~clk;

  lane_pack_queues #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_lane_pack_queues (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
    .tx_overflow(tx_overflow), .tx_cmd_valid(tx_cmd_valid), .tx_cmd_len(tx_cmd_len),
    .tx_busy(tx_busy), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
    .eng_tx_last(eng_tx_last), .eng_tx_ready(eng_tx_ready),
    .rx_cmd_valid(rx_cmd_valid), .rx_cmd_len(rx_cmd_len), .rx_busy(rx_busy),
    .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
    .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
    .rx_underflow(rx_underflow)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] w);
    tx_wr_en = 1'b1; tx_wr_data = w;
    @(negedge clk);
    tx_wr_en = 1'b0;
  endtask

  task automatic tx_cmd(input int len);
    tx_cmd_valid = 1'b1; tx_cmd_len = LEN_W'(len);
    @(negedge clk);
    tx_cmd_valid = 1'b0;
  endtask

  task automatic rx_cmd(input int len);
    rx_cmd_valid = 1'b1; rx_cmd_len = LEN_W'(len);
    @(negedge clk);
    rx_cmd_valid = 1'b0;
  endtask

  task automatic rx_feed(input logic [7:0] b);
    eng_rx_valid = 1'b1; eng_rx_byte = b;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic host_read(output logic [31:0] w);
    for (int t = 0; t < 20 && rx_empty; t++) @(negedge clk);
    check(!rx_empty, "R7 word ready", 32'(rx_empty), 32'h0);
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
    w = rx_rd_data;
  endtask

  // queue exp_b[0..len-1] as words, with filler in unused lanes
  task automatic load_tx(input int len);
    for (int j = 0; j < (len + 3) / 4; j++) begin
      logic [31:0] w;
      for (int k = 0; k < 4; k++)
        w[k*8 +: 8] = (4*j + k < len) ? exp_b[4*j + k] : 8'hA5;
      host_write(w);
    end
  endtask

  task automatic tx_consume(input int len);
    for (int i = 0; i < len; i++) begin
      string tag;
      for (int t = 0; t < 20 && !eng_tx_valid; t++) @(negedge clk);
      tag = (i == 0) ? "R2 address lane" : ((i % 4 == 0) ? "R2 word crossing" : "R1 lane order");
      check(eng_tx_valid, tag, 32'(eng_tx_valid), 32'h1);
      check(eng_tx_byte == exp_b[i], tag, 32'(eng_tx_byte), 32'(exp_b[i]));
      check(eng_tx_last == (i == len - 1), "R4 last flag", 32'(eng_tx_last), 32'(i == len - 1));
      if (i % 3 == 1) begin
        logic [7:0] held;
        held = eng_tx_byte;
        @(negedge clk); @(negedge clk);
        check(eng_tx_valid && eng_tx_byte == held, "R11 stall hold", 32'(eng_tx_byte), 32'(held));
      end
      eng_tx_ready = 1'b1;
      @(negedge clk);
      eng_tx_ready = 1'b0;
    end
    check(!tx_busy && !eng_tx_valid, "R3 exact count", 32'({tx_busy, eng_tx_valid}), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w, e;
    rst = 1'b1; soft_rst = 1'b0; tx_wr_en = 1'b0; tx_wr_data = '0;
    tx_cmd_valid = 1'b0; tx_cmd_len = '0; eng_tx_ready = 1'b0;
    rx_cmd_valid = 1'b0; rx_cmd_len = '0; eng_rx_valid = 1'b0;
    eng_rx_byte = '0; rx_rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_full && rx_empty && !tx_overflow && !rx_underflow, "R7 reset state",
          32'({tx_full, rx_empty, tx_overflow, rx_underflow}), 32'h4);
    check(!eng_tx_valid && !tx_busy && !rx_busy, "R12 reset idle",
          32'({eng_tx_valid, tx_busy, rx_busy}), 32'h0);

    // Transmit sweep over byte counts 1..9 (R1 R2 R3 R4 R11)
    for (int len = 1; len <= 9; len++) begin
      exp_b[0] = {7'(len + 32), 1'b0};
      for (int i = 1; i < len; i++) exp_b[i] = 8'(len * 17 + i * 3);
      load_tx(len);
      tx_cmd(len);
      tx_consume(len);
    end

    // Receive sweep over byte counts 1..9 (R5 R6 R7)
    for (int len = 1; len <= 9; len++) begin
      rx_cmd(len);
      for (int i = 0; i < len; i++) begin
        rx_feed(8'(len * 29 + i * 7 + 1));
        if (i % 2 == 1) @(negedge clk);
      end
      for (int j = 0; j < (len + 3) / 4; j++) begin
        e = '0;
        for (int k = 0; k < 4; k++)
          if (4*j + k < len) e[k*8 +: 8] = 8'(len * 29 + (4*j + k) * 7 + 1);
        host_read(w);
        check(w == e, (4*j + 4 > len) ? "R6 partial word" : "R5 lane packing", w, e);
      end
      check(rx_empty, "R7 empty after drain", 32'(rx_empty), 32'h1);
    end

    // R12: idle engine byte ignored, busy commands ignored
    rx_feed(8'h77);
    repeat (3) @(negedge clk);
    check(rx_empty, "R12 idle rx byte", 32'(rx_empty), 32'h1);
    rx_cmd(2);
    rx_cmd(7);
    rx_feed(8'h12); rx_feed(8'h34);
    check(!rx_busy, "R12 rx cmd while busy", 32'(rx_busy), 32'h0);
    host_read(w);
    check(w == 32'h0000_3412, "R12 rx word", w, 32'h0000_3412);
    exp_b[0] = 8'hC4;
    load_tx(1);
    tx_cmd(1);
    tx_cmd(5);
    tx_consume(1);
    check(!tx_busy, "R12 tx cmd while busy", 32'(tx_busy), 32'h0);

    // R9: overflow write dropped and sticky
    check(!tx_overflow, "R9 flag clear", 32'(tx_overflow), 32'h0);
    for (int i = 0; i < 4 * DEPTH; i++) exp_b[i] = 8'(8'h40 + i);
    load_tx(4 * DEPTH);
    check(tx_full, "R9 queue full", 32'(tx_full), 32'h1);
    host_write(32'hDEAD_BEEF);
    check(tx_overflow, "R9 overflow set", 32'(tx_overflow), 32'h1);
    tx_cmd(4 * DEPTH);
    tx_consume(4 * DEPTH);
    check(tx_overflow, "R9 overflow sticky", 32'(tx_overflow), 32'h1);
    exp_b[0] = 8'h3C;
    load_tx(1);
    tx_cmd(1);
    tx_consume(1);

    // R10: empty read ignored and sticky
    rx_rd_en = 1'b1;
    @(negedge clk);
    rx_rd_en = 1'b0;
    check(rx_underflow && rx_empty, "R10 underflow", 32'({rx_underflow, rx_empty}), 32'h3);
    @(negedge clk);
    check(rx_underflow, "R10 underflow sticky", 32'(rx_underflow), 32'h1);

    // R8: flush with partial state on both sides
    host_write(32'h1111_1111);
    host_write(32'h2222_2222);
    rx_cmd(6);
    for (int i = 0; i < 5; i++) rx_feed(8'(8'h90 + i));
    repeat (3) @(negedge clk);
    check(!rx_empty, "R8 rx word present", 32'(rx_empty), 32'h0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check(rx_empty && !tx_full && !rx_busy && !tx_busy, "R8 queues flushed",
          32'({rx_empty, tx_full, rx_busy, tx_busy}), 32'h8);
    check(!tx_overflow && !rx_underflow, "R8 flags cleared",
          32'({tx_overflow, rx_underflow}), 32'h0);
    exp_b[0] = 8'h11;
    host_write(32'h4433_2211);
    tx_cmd(1);
    tx_consume(1);
    rx_cmd(1);
    rx_feed(8'h5A);
    host_read(w);
    check(w == 32'h0000_005A, "R8 rx lane restart", w, 32'h0000_005A);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule